// File: doc/BRIEF.md
# Flash Status Register and Write Protection Unit

This unit sits beside the command decoder of a serial flash memory. It holds the status register, which consists of the write enable latch, two region-lock bits and a hardware-lock enable bit. It also watches the active-low write-protect pin. From this state it tells the decoder whether a status-register write may proceed, and whether a program or erase at a given address may proceed. It builds the byte returned by a status read. It runs the self-timed status-write cycle. The lock bits are ordinary registers with a parameterised reset value.

The decoder pulses `wren_i` and `wrdi_i` for the two latch commands. It pulses `srw_arm_i` when a status-write opcode arrives and `srw_commit_i`, with the data byte, when the select line closes the command. For array commands it presents the operation code and address. It then reads the combinational permit `arr_ok_o` in the cycle it commits. The array engine reports its own busy time through `arr_busy_i` and its completion through `arr_done_i`. For a whole-chip erase, `blk_unlocked_o` lists the 32 KiB blocks that may be erased.

Top module: `sr_guard`

## Requirements
- R1: `status_o` carries bit0 busy, bit1 write enable, bit2 lock bit 0, bit3 lock bit 1, bits 6..4 zero and bit7 hardware-lock enable. After reset it reads 8'h00.
- R2: A `wren_i` pulse sets the write enable bit and a `wrdi_i` pulse clears it, whatever the level of `wp_n_i`. While an internal cycle is busy, both pulses are ignored.
- R3: The lock bits select the protected region of the 2^ADDR_W byte array: 00 none, 01 the top quarter (17'h18000 up), 10 the top half (17'h10000 up), 11 everything. A program (`arr_op_i`=0) at a protected address is refused.
- R4: With the write enable bit clear, `arr_ok_o` and `sr_ok_o` are both 0.
- R5: With write enable set and no cycle busy, `sr_ok_o` is 1 unless the hardware-lock enable bit is 1 and `wp_n_i` is low. A commit with `sr_ok_o` low starts no cycle and leaves the status unchanged.
- R6: If `wp_n_i` is low while a status write is pending (after `srw_arm_i`, before commit) and the hardware-lock enable is 1, that write is voided, even if `wp_n_i` is high again at commit.
- R7: An accepted status write makes `status_o` read 8'hFF for SR_CYCLES cycles. After that, data bit 2 and bit 3 load the lock bits and bit 7 loads the hardware-lock enable. All other data bits are ignored, and write enable is cleared.
- R8: A change of `wp_n_i` after a status-write cycle has started does not alter its result.
- R9: A sector (`arr_op_i`=1, 4 KiB) or block (`arr_op_i`=2, 32 KiB) erase is refused when any byte of its aligned range is protected. A chip erase (`arr_op_i`=3) is permitted unless the lock bits are 11. `blk_unlocked_o[b]` is 1 exactly when block b holds no protected byte.
- R10: While `arr_busy_i` is high, `status_o` reads 8'hFF and `arr_ok_o` is 0. An `arr_done_i` pulse clears write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | High while a host command is open |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wren_i | input | 1 | Pulse: set write enable |
| wrdi_i | input | 1 | Pulse: clear write enable |
| srw_arm_i | input | 1 | Pulse: status-write opcode received |
| srw_commit_i | input | 1 | Pulse: status-write command closed |
| srw_data_i | input | 8 | Status-write data byte |
| arr_op_i | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| arr_addr_i | input | ADDR_W | Array address of the request |
| arr_busy_i | input | 1 | Array program or erase cycle in progress |
| arr_done_i | input | 1 | Pulse: array cycle finished |
| status_o | output | 8 | Status byte for the status read |
| sr_ok_o | output | 1 | Status write permitted now |
| arr_ok_o | output | 1 | Array request permitted now |
| blk_unlocked_o | output | 2^(ADDR_W-BLOCK_W) | Per-block erase permission for chip erase |

## Verification
The permits `sr_ok_o`, `arr_ok_o` and `blk_unlocked_o` are combinational. The bench therefore drives the request on a falling edge and reads them a moment later in the same cycle. A latch pulse or a commit takes effect at the next rising edge, so its effect on `status_o` is read at the following falling edge. An accepted status write keeps `status_o` at 8'hFF on the SR_CYCLES falling edges after the commit edge and shows the new bits on the one after. The bench checks both the last busy sample and the first settled one.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_BLOCK = 2'd2,
        OP_CHIP  = 2'd3
    } arr_op_e;

    // data byte bit positions used by a status write and by the status byte
    localparam int unsigned BIT_LOCK_LO = 2;
    localparam int unsigned BIT_LOCK_HI = 3;
    localparam int unsigned BIT_HWEN    = 7;

    typedef struct packed {
        logic       wel;       // write enable latch
        logic [1:0] bp;        // region lock bits
        logic       wpen;      // hardware-lock enable
        logic       pend;      // status write opcode seen, not yet committed
        logic       voided;    // pending status write cancelled by pin
        logic [1:0] sh_bp;     // staged lock bits during the write cycle
        logic       sh_wpen;   // staged hardware-lock enable
    } guard_st_t;

endpackage

// File: rtl/sr_prot_map.sv
module sr_prot_map
    import sr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned SECTOR_W = 12,
    parameter int unsigned BLOCK_W  = 15,
    parameter int unsigned PAGE_W   = 8
) (
    input  logic [1:0]                        bp_i,
    input  arr_op_e                           op_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    output logic                              hit_o,
    output logic [(1<<(ADDR_W-BLOCK_W))-1:0]  unlocked_o
);
    localparam int unsigned NBLK = 1 << (ADDR_W - BLOCK_W);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);
    localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((1 << SECTOR_W) - 1);
    localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((1 << BLOCK_W) - 1);

    logic              prot_on;
    logic [ADDR_W-1:0] prot_start;
    logic [ADDR_W-1:0] range_end;

    assign prot_on = |bp_i;

    // protected region always reaches the top of the array
    always_comb begin
        case (bp_i)
            2'b01:   prot_start = {2'b11, {(ADDR_W-2){1'b0}}};
            2'b10:   prot_start = {2'b10, {(ADDR_W-2){1'b0}}};
            default: prot_start = '0;
        endcase
    end

    // last byte touched by the request; ranges are aligned, so the
    // range overlaps the top region exactly when its last byte does
    always_comb begin
        case (op_i)
            OP_PROG:  range_end = addr_i | PAGE_MASK;
            OP_SECT:  range_end = addr_i | SECT_MASK;
            OP_BLOCK: range_end = addr_i | BLK_MASK;
            default:  range_end = addr_i;
        endcase
    end

    always_comb begin
        if (op_i == OP_CHIP) hit_o = (bp_i == 2'b11);
        else                 hit_o = prot_on && (range_end >= prot_start);
    end

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        localparam logic [ADDR_W:0] BEND = (ADDR_W+1)'(((b + 1) << BLOCK_W) - 1);
        assign unlocked_o[b] = !prot_on || (BEND < {1'b0, prot_start});
    end

endmodule

// File: rtl/sr_cycle_timer.sv
module sr_cycle_timer #(
    parameter int unsigned CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic             busy_d, busy_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);

    always_comb begin
        busy_d = busy_q;
        cnt_d  = cnt_q;
        if (busy_q) begin
            if (cnt_q == '0) busy_d = 1'b0;
            else             cnt_d  = cnt_q - 1'b1;
        end else if (start_i) begin
            busy_d = 1'b1;
            cnt_d  = CNT_W'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            busy_q <= busy_d;
            cnt_q  <= cnt_d;
        end
    end

endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int unsigned ADDR_W    = 17,
    parameter int unsigned SECTOR_W  = 12,
    parameter int unsigned BLOCK_W   = 15,
    parameter int unsigned PAGE_W    = 8,
    parameter int unsigned SR_CYCLES = 8,
    parameter logic [1:0]  BP_RST    = 2'b00
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sel_i,
    input  logic                              wp_n_i,
    input  logic                              wren_i,
    input  logic                              wrdi_i,
    input  logic                              srw_arm_i,
    input  logic                              srw_commit_i,
    input  logic [7:0]                        srw_data_i,
    input  logic [1:0]                        arr_op_i,
    input  logic [ADDR_W-1:0]                 arr_addr_i,
    input  logic                              arr_busy_i,
    input  logic                              arr_done_i,
    output logic [7:0]                        status_o,
    output logic                              sr_ok_o,
    output logic                              arr_ok_o,
    output logic [(1<<(ADDR_W-BLOCK_W))-1:0]  blk_unlocked_o
);
    guard_st_t st_d, st_q;

    logic sr_busy, sr_done, busy_all, sr_start, range_hit;
    logic unused_data;

    assign unused_data = ^{srw_data_i[6:4], srw_data_i[1:0]};

    sr_prot_map #(
        .ADDR_W  (ADDR_W),
        .SECTOR_W(SECTOR_W),
        .BLOCK_W (BLOCK_W),
        .PAGE_W  (PAGE_W)
    ) u_map (
        .bp_i      (st_q.bp),
        .op_i      (arr_op_e'(arr_op_i)),
        .addr_i    (arr_addr_i),
        .hit_o     (range_hit),
        .unlocked_o(blk_unlocked_o)
    );

    sr_cycle_timer #(
        .CYCLES(SR_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(sr_start),
        .busy_o (sr_busy),
        .done_o (sr_done)
    );

    assign busy_all = sr_busy | arr_busy_i;
    assign sr_ok_o  = st_q.wel & ~busy_all & ~(st_q.wpen & ~wp_n_i);
    assign sr_start = srw_commit_i & st_q.pend & ~st_q.voided & sr_ok_o;
    assign arr_ok_o = st_q.wel & ~busy_all & ~range_hit;

    assign status_o = busy_all ? 8'hFF
                               : {st_q.wpen, 3'b000, st_q.bp, st_q.wel, 1'b0};

    always_comb begin
        st_d = st_q;

        if (!busy_all) begin
            if (wren_i) st_d.wel = 1'b1;
            if (wrdi_i) st_d.wel = 1'b0;
        end

        // track a status write while its data is still arriving
        if (srw_arm_i && !busy_all) begin
            st_d.pend   = 1'b1;
            st_d.voided = st_q.wpen & ~wp_n_i;
        end else if (st_q.pend && st_q.wpen && !wp_n_i) begin
            st_d.voided = 1'b1;
        end
        if (srw_commit_i || !sel_i) begin
            st_d.pend   = 1'b0;
            st_d.voided = 1'b0;
        end

        if (sr_start) begin
            st_d.sh_bp   = {srw_data_i[BIT_LOCK_HI], srw_data_i[BIT_LOCK_LO]};
            st_d.sh_wpen = srw_data_i[BIT_HWEN];
        end

        if (arr_done_i) st_d.wel = 1'b0;

        if (sr_done) begin
            st_d.bp   = st_q.sh_bp;
            st_d.wpen = st_q.sh_wpen;
            st_d.wel  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.bp      <= BP_RST;
            st_q.sh_bp   <= BP_RST;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n_i,
    input logic       wrdi_i,
    input logic       arr_busy_i,
    input logic [7:0] status_o,
    input logic       sr_ok_o,
    input logic       arr_ok_o
);
    logic idle;
    assign idle = (status_o != 8'hFF);

    // R4: cleared latch blocks every write
    assert_wel_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !status_o[1]) |-> (!arr_ok_o && !sr_ok_o));

    // R10: array cycle reports busy and blocks array writes
    assert_arr_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_busy_i |-> (status_o == 8'hFF && !arr_ok_o));

    // R5: pin plus enable bit lock the status register
    assert_hw_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !wp_n_i) |-> !sr_ok_o);

    // R2: disable pulse in an idle cycle leaves the latch clear
    assert_wrdi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wrdi_i && idle && !arr_busy_i) |=> (!status_o[1] || status_o == 8'hFF));

    // R3: whole-array lock refuses every array write
    assert_full_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && status_o[3:2] == 2'b11) |-> !arr_ok_o);

    // R1: reserved and busy bits read zero when idle
    assert_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (status_o[6:4] == 3'b000 && !status_o[0]));

endmodule

bind sr_guard sr_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n_i    (wp_n_i),
    .wrdi_i    (wrdi_i),
    .arr_busy_i(arr_busy_i),
    .status_o  (status_o),
    .sr_ok_o   (sr_ok_o),
    .arr_ok_o  (arr_ok_o)
);

// File: tb/sr_guard_tb.sv
module sr_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SRC        = 8;
    localparam int NV         = 15;

    // entry: [25:24] lock bits, [23:22] op, [21:5] address, [4] permit, [3:0] block mask
    localparam logic [25:0] VEC [NV] = '{
        {2'b01, 2'd0, 17'h17FFF, 1'b1, 4'b0111},
        {2'b01, 2'd0, 17'h18000, 1'b0, 4'b0111},
        {2'b01, 2'd1, 17'h17000, 1'b1, 4'b0111},
        {2'b01, 2'd2, 17'h10000, 1'b1, 4'b0111},
        {2'b01, 2'd1, 17'h18000, 1'b0, 4'b0111},
        {2'b01, 2'd3, 17'h00000, 1'b1, 4'b0111},
        {2'b10, 2'd0, 17'h0FFFF, 1'b1, 4'b0011},
        {2'b10, 2'd0, 17'h10000, 1'b0, 4'b0011},
        {2'b10, 2'd2, 17'h08000, 1'b1, 4'b0011},
        {2'b10, 2'd2, 17'h10000, 1'b0, 4'b0011},
        {2'b10, 2'd3, 17'h00000, 1'b1, 4'b0011},
        {2'b11, 2'd0, 17'h00000, 1'b0, 4'b0000},
        {2'b11, 2'd3, 17'h00000, 1'b0, 4'b0000},
        {2'b00, 2'd0, 17'h1FFFF, 1'b1, 4'b1111},
        {2'b00, 2'd3, 17'h00000, 1'b1, 4'b1111}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0, wp_n_i = 1'b1, wren_i = 1'b0, wrdi_i = 1'b0;
    logic        srw_arm_i = 1'b0, srw_commit_i = 1'b0;
    logic [7:0]  srw_data_i = 8'h00;
    logic [1:0]  arr_op_i = 2'd0;
    logic [16:0] arr_addr_i = '0;
    logic        arr_busy_i = 1'b0, arr_done_i = 1'b0;
    logic [7:0]  status_o;
    logic        sr_ok_o, arr_ok_o;
    logic [3:0]  blk_unlocked_o;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_guard u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_i         (sel_i),
        .wp_n_i        (wp_n_i),
        .wren_i        (wren_i),
        .wrdi_i        (wrdi_i),
        .srw_arm_i     (srw_arm_i),
        .srw_commit_i  (srw_commit_i),
        .srw_data_i    (srw_data_i),
        .arr_op_i      (arr_op_i),
        .arr_addr_i    (arr_addr_i),
        .arr_busy_i    (arr_busy_i),
        .arr_done_i    (arr_done_i),
        .status_o      (status_o),
        .sr_ok_o       (sr_ok_o),
        .arr_ok_o      (arr_ok_o),
        .blk_unlocked_o(blk_unlocked_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_wren();
        @(negedge clk); wren_i = 1'b1;
        @(negedge clk); wren_i = 1'b0;
    endtask

    // ends on the falling edge right after the commit edge
    task automatic srw_send(input logic [7:0] d);
        pulse_wren();
        sel_i = 1'b1; srw_arm_i = 1'b1;
        @(negedge clk); srw_arm_i = 1'b0; srw_data_i = d; srw_commit_i = 1'b1;
        @(negedge clk); srw_commit_i = 1'b0; sel_i = 1'b0;
    endtask

    task automatic set_sr(input logic [7:0] d);
        srw_send(d);
        repeat (SRC) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] cur_bp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status_o, 8'h00);
        chk("R4 reset arr_ok", arr_ok_o, 1'b0);
        chk("R4 reset sr_ok", sr_ok_o, 1'b0);

        // table walk: region coding and erase ranges (R3, R9)
        cur_bp = 2'b00;
        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            if (v[25:24] != cur_bp) begin
                set_sr({4'b0000, v[25:24], 2'b00});
                cur_bp = v[25:24];
            end
            pulse_wren();
            arr_op_i = v[23:22]; arr_addr_i = v[21:5];
            #1;
            chk($sformatf("R3/R9 vec%0d permit", i), arr_ok_o, v[4]);
            chk($sformatf("R9 vec%0d block mask", i), blk_unlocked_o, v[3:0]);
        end
        arr_op_i = 2'd0; arr_addr_i = '0;

        // R2: disable works with the pin low
        wp_n_i = 1'b0;
        @(negedge clk); wrdi_i = 1'b1;
        @(negedge clk); wrdi_i = 1'b0;
        chk("R2 wrdi with pin low", status_o, 8'h00);
        wp_n_i = 1'b1;

        pulse_wren();
        chk("R2 wren sets latch", status_o, 8'h02);
        chk("R5 sr_ok with latch", sr_ok_o, 1'b1);

        // R7: full write, only bits 7,3,2 land, busy window
        srw_send(8'hFF);
        repeat (SRC-1) @(negedge clk);
        chk("R7 last busy sample", status_o, 8'hFF);
        @(negedge clk);
        chk("R7 settled status", status_o, 8'h8C);

        // R5: pin low with enable bit set
        wp_n_i = 1'b0;
        srw_send(8'h00);
        chk("R5 sr_ok under pin lock", sr_ok_o, 1'b0);
        @(negedge clk);
        chk("R5 refused write no busy", status_o, 8'h8E);

        // R6: pin pulse during pending write voids it
        wp_n_i = 1'b1;
        @(negedge clk); sel_i = 1'b1; srw_arm_i = 1'b1;
        @(negedge clk); srw_arm_i = 1'b0; wp_n_i = 1'b0;
        @(negedge clk); wp_n_i = 1'b1; srw_data_i = 8'h00; srw_commit_i = 1'b1;
        @(negedge clk); srw_commit_i = 1'b0; sel_i = 1'b0;
        chk("R6 voided write no busy", status_o, 8'h8E);
        repeat (SRC) @(negedge clk);
        chk("R6 voided write unchanged", status_o, 8'h8E);

        // R8: pin drop after the cycle starts has no effect
        srw_send(8'h00);
        wp_n_i = 1'b0;
        repeat (SRC) @(negedge clk);
        chk("R8 pin change mid cycle", status_o, 8'h00);
        wp_n_i = 1'b1;

        // R10 / R2: array busy
        pulse_wren();
        arr_busy_i = 1'b1;
        @(negedge clk);
        chk("R10 busy status", status_o, 8'hFF);
        chk("R10 busy arr_ok", arr_ok_o, 1'b0);
        wrdi_i = 1'b1;
        @(negedge clk); wrdi_i = 1'b0;
        arr_busy_i = 1'b0;
        @(negedge clk);
        chk("R2 wrdi ignored while busy", status_o, 8'h02);
        arr_done_i = 1'b1;
        @(negedge clk); arr_done_i = 1'b0;
        chk("R10 done clears latch", status_o, 8'h00);
        chk("R4 cleared latch arr_ok", arr_ok_o, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule